// File: doc/BRIEF.md
# Debug Breakpoint Stall Controller

This block decides when a small microcontroller's CPU must halt for an on-chip debugger. It watches the CPU bus and compares every access with one breakpoint, made of an address and an access type. When they match, it raises a registered stall request and records it in a STALL status bit. That bit is held until the external debug host clears it. The host can also set the bit directly to stop the CPU wherever it is. This abort path has no interrupt and no other side effect. While the CPU is held, the block can freeze each watchdog counter. Whether it does depends on a stop-watchdogs control bit, which is latched when that watchdog starts. A watchdog that a hardware option has forced on is never frozen.

The registers can only be reached from the host port. The CPU snoop port carries no data path into them. After reset the breakpoint is already armed as a data read of the reset vector, so a debug session catches the first data read of that address without any setup. Every stall source is gated by the debug-link active input. The breakpoint comparator is also gated by a debug-enable input.

All pins are plain control or status signals. The host port has no valid/ready pair and applies no back-pressure. A write on `host_sel & host_we` takes effect at the next rising edge. A read returns `host_rdata` in the same cycle.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: No activity on the CPU snoop port changes any register. Only a host write does.
- R2: After reset the registers read: offset 0 type = 2 (data read), offsets 1..3 = 0x00, 0x80, 0x00 (reset vector 0x008000, high byte first), offset 4 = 0, offset 5 = 0. With link and debug-enable high, a CPU data read of 0x008000 stalls the CPU with no host write.
- R3: A breakpoint match requires `cpu_valid`, an equal address, and `cpu_kind` equal to the breakpoint type. The type encoding is 0 disabled, 1 fetch, 2 data read, 3 data write, and type 0 never matches. A match sets `stall` and status bit 0 (offset 5) at the next rising edge.
- R4: Once set, `stall` stays high until the host writes 0 to bit 0 of offset 5. The clear takes effect at the next edge.
- R5: A host write of 1 to bit 0 of offset 5 (abort) raises `stall` at the next edge.
- R6: If a host clear and a match fall in the same cycle, the CPU stays stalled.
- R7: While `link_active` is low, `stall` is low, and matches and abort writes do not set the STALL bit.
- R8: `wdg_freeze[i]` is high exactly when `stall` is high, watchdog i latched the stop-watchdogs bit (offset 4 bit 0) as 1, and `wdg_hw_en[i]` is low.
- R9: Each watchdog samples the stop-watchdogs bit only on its `wdg_start[i]` pulse. Later changes to the bit do not affect it.
- R10: With `wdg_hw_en[i]` high, `wdg_freeze[i]` stays low whatever the stop-watchdogs bit.
- R11: With `dbg_en` low, breakpoint matches are ignored, while host abort still stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_active | input | 1 | Debug link active status |
| dbg_en | input | 1 | Debug enable from the link controller |
| host_sel | input | 1 | Host register access in this cycle |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, same cycle |
| cpu_valid | input | 1 | CPU bus access in this cycle |
| cpu_kind | input | 2 | CPU access type (1 fetch, 2 read, 3 write) |
| cpu_addr | input | 24 | CPU access address |
| stall | output | 1 | Stall request to the CPU |
| wdg_start | input | 2 | Per-watchdog start pulse |
| wdg_hw_en | input | 2 | Per-watchdog hardware-enable option |
| wdg_freeze | output | 2 | Per-watchdog counter freeze |

## Verification
The hardest case to reach is a watchdog whose latched freeze setting disagrees with the current stop-watchdogs bit. It needs a start pulse, then a change of the bit, then a stall, in that order. The bench starts both watchdogs with the bit set and aborts through the host. It then clears the bit and confirms the freeze persists. It restarts one watchdog and confirms only that one drops its freeze, and raises one hardware option to show the override. A host clear landing in the same cycle as a match is driven by presenting both on one clock.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_FETCH = 2'b01,
    ACC_READ  = 2'b10,
    ACC_WRITE = 2'b11
  } acc_kind_e;

  localparam int HOST_AW = 3;
  localparam int HOST_DW = 8;

  // offset of the breakpoint type register; address bytes follow it
  localparam int OFF_TYPE  = 0;
  localparam int OFF_ADDR0 = 1;

endpackage

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp
  import dbg_halt_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          arm,
  input  logic [AW-1:0] bp_addr,
  input  acc_kind_e     bp_kind,
  input  logic          cpu_valid,
  input  acc_kind_e     cpu_kind,
  input  logic [AW-1:0] cpu_addr,
  output logic          hit
);

  logic addr_eq;
  logic kind_eq;
  logic bp_live;

  assign addr_eq = (cpu_addr == bp_addr);
  assign kind_eq = (cpu_kind == bp_kind);
  assign bp_live = (bp_kind != ACC_NONE);
  assign hit     = arm & cpu_valid & bp_live & kind_eq & addr_eq;

endmodule

// File: rtl/dbg_host_regs.sv
module dbg_host_regs
  import dbg_halt_pkg::*;
#(
  parameter int          AW        = 24,
  parameter logic [AW-1:0] RESET_VEC = 24'h008000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_active,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               hit,
  output logic [AW-1:0]      bp_addr,
  output acc_kind_e          bp_kind,
  output logic               wdgoff,
  output logic               stall_q
);

  localparam int ADDR_BYTES = AW / 8;
  localparam int OFF_CTRL   = OFF_ADDR0 + ADDR_BYTES;
  localparam int OFF_STAT   = OFF_CTRL + 1;

  logic [7:0] bp_byte_q [ADDR_BYTES];
  acc_kind_e  bp_kind_q;
  logic       wdgoff_q;
  logic       wr;
  logic       wr_stat;
  logic       abort_set;
  logic       host_clr;

  assign wr        = host_sel & host_we;
  assign wr_stat   = wr & (host_addr == HOST_AW'(OFF_STAT));
  assign abort_set = wr_stat & host_wdata[0] & link_active;
  assign host_clr  = wr_stat & ~host_wdata[0];

  // breakpoint address bytes, high byte at the lowest offset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ADDR_BYTES; i++)
        bp_byte_q[i] <= RESET_VEC[(ADDR_BYTES-1-i)*8 +: 8];
    end else if (wr) begin
      for (int i = 0; i < ADDR_BYTES; i++)
        if (host_addr == HOST_AW'(OFF_ADDR0 + i))
          bp_byte_q[i] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_kind_q <= ACC_READ;
      wdgoff_q  <= 1'b0;
    end else if (wr) begin
      if (host_addr == HOST_AW'(OFF_TYPE)) bp_kind_q <= acc_kind_e'(host_wdata[1:0]);
      if (host_addr == HOST_AW'(OFF_CTRL)) wdgoff_q  <= host_wdata[0];
    end
  end

  // STALL bit: a match or abort outranks a same-cycle host clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 stall_q <= 1'b0;
    else if (hit || abort_set)  stall_q <= 1'b1;
    else if (host_clr)          stall_q <= 1'b0;
  end

  always_comb begin
    for (int i = 0; i < ADDR_BYTES; i++)
      bp_addr[(ADDR_BYTES-1-i)*8 +: 8] = bp_byte_q[i];
  end

  assign bp_kind = bp_kind_q;
  assign wdgoff  = wdgoff_q;

  always_comb begin
    host_rdata = '0;
    if (host_sel && !host_we) begin
      if (host_addr == HOST_AW'(OFF_TYPE)) host_rdata = {{(HOST_DW-2){1'b0}}, bp_kind_q};
      if (host_addr == HOST_AW'(OFF_CTRL)) host_rdata = {{(HOST_DW-1){1'b0}}, wdgoff_q};
      if (host_addr == HOST_AW'(OFF_STAT)) host_rdata = {{(HOST_DW-1){1'b0}}, stall_q};
      for (int i = 0; i < ADDR_BYTES; i++)
        if (host_addr == HOST_AW'(OFF_ADDR0 + i)) host_rdata = bp_byte_q[i];
    end
  end

  // R1: registers move only under a host write
  a_r1_host_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(bp_addr) && $stable(bp_kind) && $stable(wdgoff)));

  // R3: a comparator hit sets the STALL bit on the next edge
  a_r3_hit_sets_stall: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stall_q);

  // R4: the bit holds until a host clear
  a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q && !host_clr) |=> stall_q);

  // R6: match beats a clear in the same cycle
  a_r6_hit_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && host_clr) |=> stall_q);

  // R7: the STALL bit can only rise while the link was active
  a_r7_rise_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall_q) |-> $past(link_active));

endmodule

// File: rtl/dbg_wdg_freeze.sv
module dbg_wdg_freeze #(
  parameter int N_WDG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdgoff,
  input  logic             stall,
  input  logic [N_WDG-1:0] wdg_start,
  input  logic [N_WDG-1:0] wdg_hw_en,
  output logic [N_WDG-1:0] wdg_freeze
);

  for (genvar i = 0; i < N_WDG; i++) begin : g_wdg
    logic frz_en_q;

    // the freeze choice is taken once, when this watchdog starts
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            frz_en_q <= 1'b0;
      else if (wdg_start[i]) frz_en_q <= wdgoff;
    end

    assign wdg_freeze[i] = stall & frz_en_q & ~wdg_hw_en[i];

    // R8: no freeze unless the CPU is held
    a_r8_freeze_needs_stall: assert property (@(posedge clk) disable iff (!rst_n)
      wdg_freeze[i] |-> stall);
  end

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int            AW        = 24,
  parameter int            N_WDG     = 2,
  parameter logic [AW-1:0] RESET_VEC = 24'h008000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_active,
  input  logic               dbg_en,
  input  logic               host_sel,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic               cpu_valid,
  input  logic [1:0]         cpu_kind,
  input  logic [AW-1:0]      cpu_addr,
  output logic               stall,
  input  logic [N_WDG-1:0]   wdg_start,
  input  logic [N_WDG-1:0]   wdg_hw_en,
  output logic [N_WDG-1:0]   wdg_freeze
);

  logic          hit;
  logic          arm;
  logic [AW-1:0] bp_addr;
  acc_kind_e     bp_kind;
  logic          wdgoff;
  logic          stall_q;

  assign arm = link_active & dbg_en;

  dbg_bp_cmp #(.AW(AW)) u_cmp (
    .arm       (arm),
    .bp_addr   (bp_addr),
    .bp_kind   (bp_kind),
    .cpu_valid (cpu_valid),
    .cpu_kind  (acc_kind_e'(cpu_kind)),
    .cpu_addr  (cpu_addr),
    .hit       (hit)
  );

  dbg_host_regs #(.AW(AW), .RESET_VEC(RESET_VEC)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_active (link_active),
    .host_sel    (host_sel),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .hit         (hit),
    .bp_addr     (bp_addr),
    .bp_kind     (bp_kind),
    .wdgoff      (wdgoff),
    .stall_q     (stall_q)
  );

  // no stall request reaches the CPU while the link is down
  assign stall = stall_q & link_active;

  dbg_wdg_freeze #(.N_WDG(N_WDG)) u_frz (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdgoff     (wdgoff),
    .stall      (stall),
    .wdg_start  (wdg_start),
    .wdg_hw_en  (wdg_hw_en),
    .wdg_freeze (wdg_freeze)
  );

  // R10: a hardware-enabled watchdog is never frozen
  a_r10_hw_override: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_freeze & wdg_hw_en) == '0);

  // R11: with debug disabled, a bus access cannot raise the bit by itself
  a_r11_dbg_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_en && !host_sel && !stall_q) |=> !stall_q);

endmodule

// File: tb/dbg_halt_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_active = 1'b1;
  logic       dbg_en = 1'b1;
  logic       host_sel = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       cpu_valid = 1'b0;
  logic [1:0] cpu_kind = '0;
  logic [23:0] cpu_addr = '0;
  logic       stall;
  logic [1:0] wdg_start = '0;
  logic [1:0] wdg_hw_en = '0;
  logic [1:0] wdg_freeze;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_halt_ctrl u_dbg_halt_ctrl (
    .clk(clk), .rst_n(rst_n), .link_active(link_active), .dbg_en(dbg_en),
    .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cpu_valid(cpu_valid), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr),
    .stall(stall), .wdg_start(wdg_start), .wdg_hw_en(wdg_hw_en),
    .wdg_freeze(wdg_freeze)
  );

  // {bp_addr, bp_type, cpu_kind, cpu_addr, expected stall}
  localparam logic [52:0] VECS [8] = '{
    {24'h001234, 2'd1, 2'd1, 24'h001234, 1'b1},
    {24'h001234, 2'd1, 2'd2, 24'h001234, 1'b0},
    {24'h001234, 2'd2, 2'd2, 24'h001235, 1'b0},
    {24'hABCDEF, 2'd3, 2'd3, 24'hABCDEF, 1'b1},
    {24'hABCDEF, 2'd3, 2'd2, 24'hABCDEF, 1'b0},
    {24'h000000, 2'd0, 2'd0, 24'h000000, 1'b0},
    {24'hFFFFFF, 2'd2, 2'd2, 24'hFFFFFF, 1'b1},
    {24'h800000, 2'd1, 2'd1, 24'h000000, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // all tasks start and end just after a falling edge
  task automatic host_wr(logic [2:0] a, logic [7:0] d);
    host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(logic [2:0] a, output logic [7:0] d);
    host_sel = 1'b1; host_we = 1'b0; host_addr = a;
    #0.5 d = host_rdata;
    host_sel = 1'b0;
  endtask

  task automatic cpu_acc(logic [1:0] k, logic [23:0] a);
    cpu_valid = 1'b1; cpu_kind = k; cpu_addr = a;
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic set_bp(logic [23:0] a, logic [1:0] t);
    host_wr(3'd0, {6'd0, t});
    host_wr(3'd1, a[23:16]);
    host_wr(3'd2, a[15:8]);
    host_wr(3'd3, a[7:0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset values
    check("R2 stall at reset", stall, 0);
    host_rd(3'd0, rd); check("R2 type reset", rd, 8'h02);
    host_rd(3'd1, rd); check("R2 addr hi reset", rd, 8'h00);
    host_rd(3'd2, rd); check("R2 addr mid reset", rd, 8'h80);
    host_rd(3'd3, rd); check("R2 addr lo reset", rd, 8'h00);
    host_rd(3'd4, rd); check("R2 ctrl reset", rd, 8'h00);
    host_rd(3'd5, rd); check("R2 status reset", rd, 8'h00);

    // R1: CPU traffic, including writes, leaves registers untouched
    cpu_acc(2'd3, 24'h008000);
    cpu_acc(2'd3, 24'h000000);
    cpu_acc(2'd1, 24'h008000);
    check("R1 no stall from non-matching traffic", stall, 0);
    host_rd(3'd0, rd); check("R1 type unchanged", rd, 8'h02);
    host_rd(3'd2, rd); check("R1 addr mid unchanged", rd, 8'h80);

    // R2: reset breakpoint catches the data read of the reset vector
    cpu_acc(2'd2, 24'h008000);
    check("R2 reset vector read stalls", stall, 1);
    // R4: held over idle cycles, cleared by host
    repeat (4) @(negedge clk);
    check("R4 stall held", stall, 1);
    host_wr(3'd5, 8'h00);
    check("R4 host clear resumes", stall, 0);

    // R3: vector table
    for (int i = 0; i < 8; i++) begin
      logic [52:0] v;
      v = VECS[i];
      set_bp(v[52:29], v[28:27]);
      cpu_acc(v[26:25], v[24:1]);
      check($sformatf("R3 vector %0d stall", i), stall, v[0]);
      host_rd(3'd5, rd);
      check($sformatf("R3 vector %0d status", i), rd, {7'd0, v[0]});
      host_wr(3'd5, 8'h00);
    end

    // R5: abort
    set_bp(24'h008000, 2'd2);
    host_wr(3'd5, 8'h01);
    check("R5 abort stalls", stall, 1);
    // R6: same-cycle clear and match
    host_sel = 1'b1; host_we = 1'b1; host_addr = 3'd5; host_wdata = 8'h00;
    cpu_valid = 1'b1; cpu_kind = 2'd2; cpu_addr = 24'h008000;
    @(negedge clk);
    host_sel = 1'b0; host_we = 1'b0; cpu_valid = 1'b0;
    check("R6 match beats clear", stall, 1);
    host_wr(3'd5, 8'h00);
    check("R6 later clear resumes", stall, 0);

    // R7: link down
    link_active = 1'b0;
    cpu_acc(2'd2, 24'h008000);
    check("R7 no stall on match, link down", stall, 0);
    host_wr(3'd5, 8'h01);
    check("R7 no stall on abort, link down", stall, 0);
    link_active = 1'b1;
    #0.5;
    check("R7 nothing latched while down", stall, 0);
    host_wr(3'd5, 8'h01);
    link_active = 1'b0;
    #0.5;
    check("R7 stall masked when link drops", stall, 0);
    link_active = 1'b1;
    host_wr(3'd5, 8'h00);

    // R11: debug disabled
    dbg_en = 1'b0;
    cpu_acc(2'd2, 24'h008000);
    check("R11 match ignored, debug off", stall, 0);
    host_wr(3'd5, 8'h01);
    check("R11 abort works, debug off", stall, 1);
    host_wr(3'd5, 8'h00);
    dbg_en = 1'b1;

    // R8 / R9 / R10: watchdog freeze
    host_wr(3'd4, 8'h01);
    wdg_start = 2'b11; @(negedge clk); wdg_start = 2'b00;
    check("R8 no freeze without stall", wdg_freeze, 2'b00);
    host_wr(3'd5, 8'h01);
    check("R8 both frozen while stalled", wdg_freeze, 2'b11);
    wdg_hw_en = 2'b10; #0.5;
    check("R10 hw option blocks freeze", wdg_freeze, 2'b01);
    host_wr(3'd4, 8'h00);
    check("R9 latched freeze survives bit change", wdg_freeze, 2'b01);
    wdg_start = 2'b01; @(negedge clk); wdg_start = 2'b00;
    check("R9 restart takes new bit", wdg_freeze, 2'b00);
    wdg_hw_en = 2'b00; #0.5;
    host_wr(3'd5, 8'h00);
    check("R8 freeze drops on resume", wdg_freeze, 2'b00);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule